// File: doc/BRIEF.md
# Asynchronous Interrupt Acceptance Controller

This block sits beside the commit stage of a simple in-order pipelined core. It decides in which cycle a maskable asynchronous interrupt may be taken. Four request lines feed it: external, system-management, timer-decrementer and critical. Each line has its own enable bit, and one global enable covers them all. A request that is enabled is never taken at an arbitrary point. The block waits for an instruction boundary, which is either the completion of an instruction or a cycle in which the execution units are idle.

A completing instruction that raises its own exception is handled before any asynchronous interrupt. A guarded load that is already outstanding on the bus is never cut short, so acceptance waits until its data has returned.

When an interrupt is accepted, the block does four things in one cycle:

- it emits a one-cycle take pulse;
- it raises the flush request for the younger instructions that have not completed;
- it presents a 2-bit cause code;
- it captures the restart address for the handler's save/restore register.

In the same cycle it clears the global enable. The enable stays cleared until software sets it again.

Top module: `async_irq_accept`

## Requirements
- R1: After reset the outputs are as follows: `irq_take`=0, `pipe_flush`=0, `irq_cause`=0 and `restart_pc`=0. The global enable comes out of reset at `GIE_RESET` (default 1), so an enabled request at the first boundary after reset is taken.
- R2: A source is pending in a cycle when its `irq_req` bit, its `irq_en` bit and the global enable are all 1. A boundary is a cycle in which `done_vld`=1 with `done_exc`=0, or a cycle in which `pipe_idle`=1 with `done_vld`=0. A pending source is accepted only in a boundary cycle. No acceptance happens while `done_vld`=0 and `pipe_idle`=0. `irq_take` asserts in the cycle after the accepting cycle.
- R3: `irq_take` is high for exactly one cycle per acceptance, and `pipe_flush` equals `irq_take` in every cycle.
- R4: No acceptance happens in a cycle in which `guard_ld_busy`=1. A request still pending is accepted at the first boundary after `guard_ld_busy` returns to 0.
- R5: No acceptance happens in a cycle in which `done_vld`=1 and `done_exc`=1. The pending request is taken at a later boundary.
- R6: The request bits are indexed as follows: bit 0 external, bit 1 system-management, bit 2 decrementer, bit 3 critical. `irq_cause` carries the index of the source that was accepted. When several sources are pending, the winner follows the fixed order critical, then system-management, then external, then decrementer.
- R7: A request whose `irq_en` bit is 0 is ignored. Requests are level-sensitive: a request that falls before a boundary is dropped and never taken.
- R8: `restart_pc` presented with `irq_take` depends on the accepting cycle. It is the `done_npc` of that cycle when `done_vld`=1, and otherwise the `fetch_pc` of that cycle.
- R9: Acceptance clears the global enable in the same cycle. No further interrupt is taken until a `gie_set` pulse sets it again, which takes effect from the next cycle. When `gie_set` arrives in an accepting cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 4 | Level-sensitive request lines (bit 0 ext, 1 sys-mgmt, 2 decrementer, 3 critical) |
| irq_en | input | 4 | Per-source enable bits |
| gie_set | input | 1 | Software pulse that sets the global enable |
| done_vld | input | 1 | An instruction completes this cycle |
| done_exc | input | 1 | The completing instruction raised its own exception |
| done_npc | input | AW | Address of the instruction after the completing one |
| pipe_idle | input | 1 | No instruction in the execution units |
| fetch_pc | input | AW | Current fetch address |
| guard_ld_busy | input | 1 | A guarded load is on the bus and its data has not returned |
| irq_take | output | 1 | One-cycle take pulse |
| irq_cause | output | 2 | Index of the accepted source |
| restart_pc | output | AW | Captured restart address |
| pipe_flush | output | 1 | Flush request for younger uncompleted instructions |

## Verification
The bench builds the block with `AW`=16 and `GIE_RESET`=1. The narrow address width makes each restart address easy to read. The set global enable makes the first boundary after reset an immediate acceptance. A scoreboard models the global enable on its own and predicts, cycle by cycle, whether a take occurs, along with its cause and restart address.

The stimulus covers several cases:
- boundaries held off by a busy pipeline, an outstanding guarded load and an excepting instruction;
- every multi-source priority combination that decides a different winner;
- masked and withdrawn requests;
- the collision of a re-enable with an acceptance.

// File: rtl/irq_acc_pkg.sv
package irq_acc_pkg;

   localparam int unsigned NSRC = 4;
   localparam int unsigned CW   = $clog2(NSRC);

   typedef enum logic [1:0] {
      CAUSE_EXT  = 2'd0,
      CAUSE_SMI  = 2'd1,
      CAUSE_DEC  = 2'd2,
      CAUSE_CRIT = 2'd3
   } irq_cause_e;

   // rank 0 is the highest priority (R6)
   localparam irq_cause_e PRIO_RANK [NSRC] = '{CAUSE_CRIT, CAUSE_SMI, CAUSE_EXT, CAUSE_DEC};

endpackage

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
   import irq_acc_pkg::*;
(
   input  logic [NSRC-1:0] pend,
   output logic            any_pend,
   output logic [CW-1:0]   win_cause
);

   logic [NSRC:0]   blocked;
   logic [NSRC-1:0] win_rank;

   assign blocked[0] = 1'b0;

   for (genvar r = 0; r < NSRC; r++) begin : g_rank
      assign win_rank[r]    = pend[PRIO_RANK[r]] & ~blocked[r];
      assign blocked[r + 1] = blocked[r] | pend[PRIO_RANK[r]];
   end

   assign any_pend = blocked[NSRC];

   always_comb begin
      win_cause = '0;
      for (int r = 0; r < NSRC; r++) begin
         if (win_rank[r]) win_cause = CW'(PRIO_RANK[r]);
      end
   end

   // R6: at most one rank wins
   always_comb begin
      a_r6_one_winner: assert ($onehot0(win_rank));
   end

endmodule

// File: rtl/irq_boundary_gate.sv
module irq_boundary_gate #(
   parameter bit GIE_RESET = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic any_masked,
   input  logic gie_set,
   input  logic done_vld,
   input  logic done_exc,
   input  logic pipe_idle,
   input  logic guard_ld_busy,
   output logic accept,
   output logic gie
);

   logic at_commit;
   logic at_idle;
   logic boundary_ok;

   assign at_commit   = done_vld & ~done_exc;
   assign at_idle     = pipe_idle & ~done_vld;
   assign boundary_ok = ~guard_ld_busy & (at_commit | at_idle);
   assign accept      = any_masked & gie & boundary_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       gie <= GIE_RESET;
      else if (accept)  gie <= 1'b0;
      else if (gie_set) gie <= 1'b1;
   end

   a_r2_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_vld && !pipe_idle) |-> !accept);

   a_r4_guarded_load_holds: assert property (@(posedge clk) disable iff (!rst_n)
      guard_ld_busy |-> !accept);

   a_r5_exception_first: assert property (@(posedge clk) disable iff (!rst_n)
      (done_vld && done_exc) |-> !accept);

   a_r9_gie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !gie);

endmodule

// File: rtl/irq_restart_cap.sv
module irq_restart_cap
   import irq_acc_pkg::*;
#(
   parameter int unsigned AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic [CW-1:0] win_cause,
   input  logic          done_vld,
   input  logic [AW-1:0] done_npc,
   input  logic [AW-1:0] fetch_pc,
   output logic          take_q,
   output logic [CW-1:0] cause_q,
   output logic [AW-1:0] restart_q
);

   logic [AW-1:0] restart_d;

   assign restart_d = done_vld ? done_npc : fetch_pc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_q    <= 1'b0;
         cause_q   <= '0;
         restart_q <= '0;
      end else begin
         take_q <= accept;
         if (accept) begin
            cause_q   <= win_cause;
            restart_q <= restart_d;
         end
      end
   end

   a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(restart_q));

endmodule

// File: rtl/async_irq_accept.sv
module async_irq_accept
   import irq_acc_pkg::*;
#(
   parameter int unsigned AW        = 32,
   parameter bit          GIE_RESET = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [3:0]    irq_req,
   input  logic [3:0]    irq_en,
   input  logic          gie_set,
   input  logic          done_vld,
   input  logic          done_exc,
   input  logic [AW-1:0] done_npc,
   input  logic          pipe_idle,
   input  logic [AW-1:0] fetch_pc,
   input  logic          guard_ld_busy,
   output logic          irq_take,
   output logic [1:0]    irq_cause,
   output logic [AW-1:0] restart_pc,
   output logic          pipe_flush
);

   if (AW < 2) begin : g_bad_aw
      $error("async_irq_accept: AW must be at least 2");
   end
   if (NSRC != 4 || CW != 2) begin : g_bad_nsrc
      $error("async_irq_accept: source count must be 4");
   end

   logic [NSRC-1:0] masked;
   logic            any_masked;
   logic [CW-1:0]   win_cause;
   logic            accept;
   logic            gie;

   assign masked = irq_req & irq_en;

   irq_prio_sel u_prio (
      .pend      (masked),
      .any_pend  (any_masked),
      .win_cause (win_cause)
   );

   irq_boundary_gate #(.GIE_RESET(GIE_RESET)) u_gate (
      .clk           (clk),
      .rst_n         (rst_n),
      .any_masked    (any_masked),
      .gie_set       (gie_set),
      .done_vld      (done_vld),
      .done_exc      (done_exc),
      .pipe_idle     (pipe_idle),
      .guard_ld_busy (guard_ld_busy),
      .accept        (accept),
      .gie           (gie)
   );

   irq_restart_cap #(.AW(AW)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .win_cause (win_cause),
      .done_vld  (done_vld),
      .done_npc  (done_npc),
      .fetch_pc  (fetch_pc),
      .take_q    (irq_take),
      .cause_q   (irq_cause),
      .restart_q (restart_pc)
   );

   assign pipe_flush = irq_take;

   // checker state: enabled requests of the previous cycle
   logic [3:0] masked_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) masked_d <= '0;
      else        masked_d <= masked;
   end

   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |=> !irq_take);

   a_r3_flush_with_take: assert property (@(posedge clk) disable iff (!rst_n)
      pipe_flush == irq_take);

   a_r9_no_take_while_off: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> !gie);

   a_r7_cause_was_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> masked_d[irq_cause]);

   a_r8_npc_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_take && $past(done_vld)) |-> (restart_pc == $past(done_npc)));

   a_r8_fetch_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_take && !$past(done_vld)) |-> (restart_pc == $past(fetch_pc)));

endmodule

// File: tb/async_irq_accept_test.sv
module async_irq_accept_test;

   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    irq_req = '0;
   logic [3:0]    irq_en = '0;
   logic          gie_set = 1'b0;
   logic          done_vld = 1'b0;
   logic          done_exc = 1'b0;
   logic [AW-1:0] done_npc = '0;
   logic          pipe_idle = 1'b0;
   logic [AW-1:0] fetch_pc = '0;
   logic          guard_ld_busy = 1'b0;
   logic          irq_take;
   logic [1:0]    irq_cause;
   logic [AW-1:0] restart_pc;
   logic          pipe_flush;

   always #5 clk = ~clk;

   async_irq_accept #(.AW(AW), .GIE_RESET(1'b1)) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .irq_req       (irq_req),
      .irq_en        (irq_en),
      .gie_set       (gie_set),
      .done_vld      (done_vld),
      .done_exc      (done_exc),
      .done_npc      (done_npc),
      .pipe_idle     (pipe_idle),
      .fetch_pc      (fetch_pc),
      .guard_ld_busy (guard_ld_busy),
      .irq_take      (irq_take),
      .irq_cause     (irq_cause),
      .restart_pc    (restart_pc),
      .pipe_flush    (pipe_flush)
   );

   typedef struct {
      bit            take;
      logic [1:0]    cause;
      logic [AW-1:0] addr;
      string         tag;
   } exp_t;

   exp_t q[$];
   exp_t e;
   int   tests = 0;
   int   fails = 0;
   bit   m_gie = 1'b1;
   bit   done_flag = 1'b0;

   // monitor: one expected item per driven cycle
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         e = q.pop_front();
         tests++;
         if (irq_take !== e.take) begin
            fails++;
            $display("FAIL %s: irq_take=%0b expected %0b", e.tag, irq_take, e.take);
         end else if (e.take && (irq_cause !== e.cause || restart_pc !== e.addr)) begin
            fails++;
            $display("FAIL %s: cause=%0d pc=%h expected cause=%0d pc=%h",
                     e.tag, irq_cause, restart_pc, e.cause, e.addr);
         end
         tests++;
         if (pipe_flush !== irq_take) begin
            fails++;
            $display("FAIL R3: pipe_flush=%0b expected %0b", pipe_flush, irq_take);
         end
      end
   end

   task automatic step(input logic [3:0] req, input logic [3:0] en,
                       input logic dv, input logic dx, input logic [AW-1:0] npc,
                       input logic idle, input logic [AW-1:0] fpc,
                       input logic gld, input logic gset, input string tag);
      bit [3:0] pend;
      bit       acc;
      exp_t     x;
      @(negedge clk);
      irq_req = req; irq_en = en; done_vld = dv; done_exc = dx; done_npc = npc;
      pipe_idle = idle; fetch_pc = fpc; guard_ld_busy = gld; gie_set = gset;
      pend = req & en & {4{m_gie}};
      acc  = (pend != 0) && !gld && ((dv && !dx) || (idle && !dv));
      x.take = acc;
      x.tag  = tag;
      x.addr = dv ? npc : fpc;
      if (pend[3])      x.cause = 2'd3;
      else if (pend[1]) x.cause = 2'd1;
      else if (pend[0]) x.cause = 2'd0;
      else              x.cause = 2'd2;
      q.push_back(x);
      if (acc)       m_gie = 1'b0;
      else if (gset) m_gie = 1'b1;
   endtask

   task automatic reenable();
      step(4'h0, 4'hF, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1, "R9");
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      #1000000;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      tests++;
      if (irq_take !== 1'b0 || pipe_flush !== 1'b0 || irq_cause !== 2'd0 || restart_pc !== '0) begin
         fails++;
         $display("FAIL R1: take=%0b flush=%0b cause=%0d pc=%h expected all zero",
                  irq_take, pipe_flush, irq_cause, restart_pc);
      end
      rst_n = 1'b1;

      // R1: enable on out of reset, immediate take at first boundary
      step(4'b0001, 4'hF, 1'b1, 1'b0, 16'h0040, 1'b0, 16'h0000, 1'b0, 1'b0, "R1");
      // R9: global enable now off
      step(4'b0001, 4'hF, 1'b1, 1'b0, 16'h0044, 1'b0, 16'h0000, 1'b0, 1'b0, "R9");
      step(4'b0001, 4'hF, 1'b1, 1'b0, 16'h0048, 1'b0, 16'h0000, 1'b0, 1'b1, "R9");
      // R2: busy pipeline holds off, then commit boundary
      step(4'b0001, 4'hF, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0200, 1'b0, 1'b0, "R2");
      step(4'b0001, 4'hF, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0204, 1'b0, 1'b0, "R2");
      step(4'b0001, 4'hF, 1'b1, 1'b0, 16'h0104, 1'b0, 16'h0208, 1'b0, 1'b0, "R2");
      reenable();
      // R4: guarded load outstanding
      step(4'b1000, 4'hF, 1'b1, 1'b0, 16'h0300, 1'b0, 16'h0000, 1'b1, 1'b0, "R4");
      step(4'b1000, 4'hF, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0310, 1'b1, 1'b0, "R4");
      step(4'b1000, 4'hF, 1'b1, 1'b0, 16'h0304, 1'b0, 16'h0000, 1'b0, 1'b0, "R4");
      reenable();
      // R5: excepting instruction goes first
      step(4'b0010, 4'hF, 1'b1, 1'b1, 16'h0400, 1'b0, 16'h0000, 1'b0, 1'b0, "R5");
      step(4'b0010, 4'hF, 1'b1, 1'b0, 16'h0408, 1'b0, 16'h0000, 1'b0, 1'b0, "R5");
      reenable();
      // R6: priority combinations
      step(4'b1111, 4'hF, 1'b1, 1'b0, 16'h0500, 1'b0, 16'h0000, 1'b0, 1'b0, "R6");
      reenable();
      step(4'b0111, 4'hF, 1'b1, 1'b0, 16'h0510, 1'b0, 16'h0000, 1'b0, 1'b0, "R6");
      reenable();
      step(4'b0101, 4'hF, 1'b1, 1'b0, 16'h0520, 1'b0, 16'h0000, 1'b0, 1'b0, "R6");
      reenable();
      step(4'b0100, 4'hF, 1'b1, 1'b0, 16'h0530, 1'b0, 16'h0000, 1'b0, 1'b0, "R6");
      reenable();
      // R7: masked source ignored, withdrawn request dropped
      step(4'b0001, 4'h0, 1'b1, 1'b0, 16'h0540, 1'b0, 16'h0000, 1'b0, 1'b0, "R7");
      step(4'b1111, 4'b0100, 1'b1, 1'b0, 16'h0544, 1'b0, 16'h0000, 1'b0, 1'b0, "R7");
      reenable();
      step(4'b0001, 4'hF, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0550, 1'b0, 1'b0, "R7");
      step(4'b0000, 4'hF, 1'b1, 1'b0, 16'h0554, 1'b0, 16'h0000, 1'b0, 1'b0, "R7");
      // R8: idle pipeline uses fetch address; commit wins over idle
      step(4'b0010, 4'hF, 1'b0, 1'b0, 16'h0111, 1'b1, 16'h05A0, 1'b0, 1'b0, "R8");
      reenable();
      step(4'b0010, 4'hF, 1'b1, 1'b0, 16'h05B4, 1'b1, 16'h05C0, 1'b0, 1'b0, "R8");
      reenable();
      // R9: re-enable colliding with acceptance, clear wins
      step(4'b0001, 4'hF, 1'b1, 1'b0, 16'h0600, 1'b0, 16'h0000, 1'b0, 1'b1, "R9");
      step(4'b0001, 4'hF, 1'b1, 1'b0, 16'h0604, 1'b0, 16'h0000, 1'b0, 1'b0, "R9");
      reenable();
      step(4'b0001, 4'hF, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0610, 1'b0, 1'b0, "R9");
      // drain
      step(4'b0000, 4'h0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R3");
      repeat (3) @(posedge clk);
      #3;
      tests++;
      if (q.size() != 0) begin
         fails++;
         $display("FAIL R3: %0d expected items left, expected 0", q.size());
      end
      finish_run();
   end

endmodule